// File: doc/BRIEF.md
# PCI DMA Address Translator

This block turns a DMA address issued by a PCI device into a system memory address. Each request is classified by its bit pattern into one of three paths. A 64-bit address with bit 56 set goes straight through. A 32-bit address in the upper half of the 32-bit space falls in a 2 GB direct window, which is added to a programmable base. A 32-bit address in the 1 GB region below that is translated page by page through a table of translation entries, and each entry can point anywhere in system memory.

The table holds 128 entries by default, or 1024 in the extended variant. All entries share one page size, 4 KB or 16 KB, chosen by a configuration input. Each entry has its own valid bit, and the entries are loaded through a single write port. The byte-swap decision depends on the path and the variant. In the direct window it comes from a per-device configuration bit. In the translated window the base variant also uses the per-device bit, while the extended variant takes it from address bit 29, so every entry can be reached at two aliases: one unswapped and one swapped.

Every request gives one registered response a cycle later. The response carries the system address, the swap flag, a path code and a fault flag. A fault means the address was not issued.

Top module: `dma_xlate`

## Requirements
- R1: While reset is low and in the first cycle after it, `rsp_valid` is 0. Reset clears every table entry's valid bit, so a translated lookup before any table write faults.
- R2: `rsp_valid` equals the `req_valid` of the previous cycle, and the response describes that earlier request.
- R3: When `req_addr[63:32]` is nonzero and bit 56 is set, the response carries `req_addr[SYS_AW-1:0]`, with swap 0 and path code 1.
- R4: When `req_addr[63:32]` is zero and bit 31 is set, the response address is `dwin_base + req_addr[30:0]` modulo 2^SYS_AW. The swap flag is `dev_swap[req_dev]` and the path code is 2.
- R5: When `req_addr[63:32]` is zero and `req_addr[31:30]` is 2'b01, the lookup uses path code 3. With 4 KB pages (`page_16k`=0) the entry index is the window offset shifted right by 12, and the address is `{pfn, offset[11:0]}`.
- R6: With 16 KB pages (`page_16k`=1) the index is the window offset shifted right by 14, and the address is `{pfn[PFN_W-1:2], offset[13:0]}`.
- R7: In the base variant (EXTENDED=0) the window offset is `req_addr[29:0]` and the swap flag is `dev_swap[req_dev]`. In the extended variant (EXTENDED=1) the offset is `req_addr[28:0]` and the swap flag is `req_addr[29]`.
- R8: A translated lookup that hits an entry whose valid bit is clear sets `rsp_fault`, with `rsp_addr` 0 and `rsp_swap` 0.
- R9: A translated lookup whose index is ENTRIES or more faults in the same way as R8.
- R10: A request that matches no path faults with path code 0 and address 0. These are a 32-bit address below 0x4000_0000, and an address with a nonzero upper half but bit 56 clear.
- R11: A table write takes effect at the next clock edge. A lookup in the same cycle as a write to the same entry sees the old contents, and a lookup in the following cycle sees the new contents.
- R12: Writing an entry with `tbl_wr_valid`=0 invalidates it, so later lookups of that entry fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_16k | input | 1 | Page size select: 0 for 4 KB, 1 for 16 KB |
| dwin_base | input | SYS_AW | Base address of the direct window |
| dev_swap | input | N_DEV | Per-device swap bits |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_idx | input | IDX_W | Table entry to write |
| tbl_wr_valid | input | 1 | Valid bit written to the entry |
| tbl_wr_pfn | input | PFN_W | System page frame, address bits [SYS_AW-1:12] |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | PCI DMA address |
| req_dev | input | DEV_W | Requesting device number |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | SYS_AW | System address, 0 on fault |
| rsp_swap | output | 1 | Byte-swap flag |
| rsp_fault | output | 1 | Request not issued |
| rsp_path | output | 2 | 0 none, 1 direct 64-bit, 2 direct window, 3 translated |

## Verification
The bench builds two instances side by side, both with SYS_AW=40 and eight devices, and drives both with the same stimulus. The first instance is the base variant with 128 entries, so index 128 reaches the out-of-range fault. In this variant an address with bit 29 set lands far beyond the table. The second instance is the extended variant with 1024 entries. Here index 128 is a legal entry that was never written, and the bit-29 alias swaps the same entry that the unswapped alias reaches.

// File: rtl/dma_xlate_pkg.sv
// Shared types and constants for the DMA address translator.
// Assumes: the path code is visible at the top level as a 2-bit field.
package dma_xlate_pkg;

    typedef enum logic [1:0] {
        PATH_NONE      = 2'd0,
        PATH_DIRECT64  = 2'd1,
        PATH_WINDOW    = 2'd2,
        PATH_TRANSLATE = 2'd3
    } path_e;

    localparam int PAGE_SHIFT_4K  = 12;
    localparam int PAGE_SHIFT_16K = 14;
    localparam int WIN_OFF_W      = 30;

endpackage

// File: rtl/dma_classify.sv
// Address classifier: decodes the DMA address into a path, computes the
// direct result, and derives the table index, the in-range flag and the swap
// source for the translated path.
// Assumes: SYS_AW > 31; purely combinational.
module dma_classify
    import dma_xlate_pkg::*;
#(
    parameter int SYS_AW   = 40,
    parameter int N_DEV    = 8,
    parameter int ENTRIES  = 128,
    parameter bit EXTENDED = 1'b0,
    localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [63:0]        addr,
    input  logic [DEV_W-1:0]   dev,
    input  logic [N_DEV-1:0]   dev_swap,
    input  logic [SYS_AW-1:0]  dwin_base,
    input  logic               page_16k,
    output path_e              path,
    output logic [SYS_AW-1:0]  direct_addr,
    output logic               direct_swap,
    output logic [IDX_W-1:0]   idx,
    output logic               idx_ok,
    output logic               xl_swap,
    output logic [13:0]        page_off
);

    logic                 upper_nz;
    logic                 dev_bit;
    logic [WIN_OFF_W-1:0] win_off;
    logic [WIN_OFF_W-1:0] page_num;

    assign upper_nz = |addr[63:32];
    assign dev_bit  = dev_swap[dev];

    // Variant choice: where the window offset and the translated swap come from.
    generate
        if (EXTENDED) begin : g_alias
            assign win_off = {1'b0, addr[28:0]};
            assign xl_swap = addr[29];
        end else begin : g_devbit
            assign win_off = addr[29:0];
            assign xl_swap = dev_bit;
        end
    endgenerate

    // Path decode from the address pattern.
    always_comb begin
        if (upper_nz) begin
            path = addr[56] ? PATH_DIRECT64 : PATH_NONE;
        end else if (addr[31]) begin
            path = PATH_WINDOW;
        end else if (addr[30]) begin
            path = PATH_TRANSLATE;
        end else begin
            path = PATH_NONE;
        end
    end

    // Direct results: passthrough or window base plus offset.
    always_comb begin
        if (path == PATH_DIRECT64) begin
            direct_addr = addr[SYS_AW-1:0];
            direct_swap = 1'b0;
        end else begin
            direct_addr = dwin_base + {{(SYS_AW-31){1'b0}}, addr[30:0]};
            direct_swap = dev_bit;
        end
    end

    // Page number, index and range check for the selected page size.
    always_comb begin
        page_num = page_16k ? (win_off >> PAGE_SHIFT_16K) : (win_off >> PAGE_SHIFT_4K);
        idx_ok   = (page_num < WIN_OFF_W'(ENTRIES));
        idx      = page_num[IDX_W-1:0];
        page_off = win_off[13:0];
    end

endmodule

// File: rtl/dma_ate_table.sv
// Translation entry table: a page frame array with a separate valid vector.
// One write port, one combinational read port; a write lands at the clock
// edge, so a same-cycle read returns the old contents.
// Assumes: only the valid bits need a reset value.
module dma_ate_table #(
    parameter int ENTRIES = 128,
    parameter int PFN_W   = 28,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [PFN_W-1:0] rd_pfn
);

    logic [ENTRIES-1:0] valid_q;
    logic [PFN_W-1:0]   pfn_q [ENTRIES];

    // Valid bits: cleared by reset, updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    // Frame storage: written with no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pfn_q[wr_idx] <= wr_pfn;
        end
    end

    // Read port: current contents, before any write at this edge.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_pfn   = pfn_q[rd_idx];
    end

endmodule

// File: rtl/dma_resolve.sv
// Result selector: merges the direct and translated results into one
// address, swap and fault outcome for the decoded path.
// Assumes: a fault forces the address and swap to zero.
module dma_resolve
    import dma_xlate_pkg::*;
#(
    parameter int SYS_AW = 40,
    localparam int PFN_W = SYS_AW - PAGE_SHIFT_4K
) (
    input  path_e              path,
    input  logic [SYS_AW-1:0]  direct_addr,
    input  logic               direct_swap,
    input  logic               idx_ok,
    input  logic               xl_swap,
    input  logic [13:0]        page_off,
    input  logic               page_16k,
    input  logic               ent_valid,
    input  logic [PFN_W-1:0]   ent_pfn,
    output logic [SYS_AW-1:0]  out_addr,
    output logic               out_swap,
    output logic               out_fault
);

    logic [SYS_AW-1:0] xl_addr;

    // Page frame joined with the in-page offset for the active page size.
    always_comb begin
        if (page_16k) begin
            xl_addr = {ent_pfn[PFN_W-1:2], page_off[13:0]};
        end else begin
            xl_addr = {ent_pfn, page_off[11:0]};
        end
    end

    // Path multiplexer with fault suppression.
    always_comb begin
        out_addr  = '0;
        out_swap  = 1'b0;
        out_fault = 1'b0;
        unique case (path)
            PATH_DIRECT64, PATH_WINDOW: begin
                out_addr = direct_addr;
                out_swap = direct_swap;
            end
            PATH_TRANSLATE: begin
                if (idx_ok && ent_valid) begin
                    out_addr = xl_addr;
                    out_swap = xl_swap;
                end else begin
                    out_fault = 1'b1;
                end
            end
            default: out_fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/dma_xlate.sv
// DMA address translator top: classifies each request, looks up the table,
// and registers a one-cycle response.
// Assumes: configuration inputs are stable around requests that use them.
module dma_xlate
    import dma_xlate_pkg::*;
#(
    parameter int SYS_AW   = 40,
    parameter int N_DEV    = 8,
    parameter int ENTRIES  = 128,
    parameter bit EXTENDED = 1'b0,
    localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int PFN_W   = SYS_AW - PAGE_SHIFT_4K
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_16k,
    input  logic [SYS_AW-1:0] dwin_base,
    input  logic [N_DEV-1:0]  dev_swap,
    input  logic              tbl_wr_en,
    input  logic [IDX_W-1:0]  tbl_wr_idx,
    input  logic              tbl_wr_valid,
    input  logic [PFN_W-1:0]  tbl_wr_pfn,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [DEV_W-1:0]  req_dev,
    output logic              rsp_valid,
    output logic [SYS_AW-1:0] rsp_addr,
    output logic              rsp_swap,
    output logic              rsp_fault,
    output logic [1:0]        rsp_path
);

    path_e             path;
    logic [SYS_AW-1:0] direct_addr;
    logic              direct_swap;
    logic [IDX_W-1:0]  idx;
    logic              idx_ok;
    logic              xl_swap;
    logic [13:0]       page_off;
    logic              ent_valid;
    logic [PFN_W-1:0]  ent_pfn;
    logic [SYS_AW-1:0] res_addr;
    logic              res_swap;
    logic              res_fault;

    dma_classify #(
        .SYS_AW   (SYS_AW),
        .N_DEV    (N_DEV),
        .ENTRIES  (ENTRIES),
        .EXTENDED (EXTENDED)
    ) u_classify (
        .addr        (req_addr),
        .dev         (req_dev),
        .dev_swap    (dev_swap),
        .dwin_base   (dwin_base),
        .page_16k    (page_16k),
        .path        (path),
        .direct_addr (direct_addr),
        .direct_swap (direct_swap),
        .idx         (idx),
        .idx_ok      (idx_ok),
        .xl_swap     (xl_swap),
        .page_off    (page_off)
    );

    dma_ate_table #(
        .ENTRIES (ENTRIES),
        .PFN_W   (PFN_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_idx   (tbl_wr_idx),
        .wr_valid (tbl_wr_valid),
        .wr_pfn   (tbl_wr_pfn),
        .rd_idx   (idx),
        .rd_valid (ent_valid),
        .rd_pfn   (ent_pfn)
    );

    dma_resolve #(
        .SYS_AW (SYS_AW)
    ) u_resolve (
        .path        (path),
        .direct_addr (direct_addr),
        .direct_swap (direct_swap),
        .idx_ok      (idx_ok),
        .xl_swap     (xl_swap),
        .page_off    (page_off),
        .page_16k    (page_16k),
        .ent_valid   (ent_valid),
        .ent_pfn     (ent_pfn),
        .out_addr    (res_addr),
        .out_swap    (res_swap),
        .out_fault   (res_fault)
    );

    // Response register: one cycle after the request, zeroed when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_swap  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_path  <= PATH_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_addr  <= req_valid ? res_addr : '0;
            rsp_swap  <= req_valid & res_swap;
            rsp_fault <= req_valid & res_fault;
            rsp_path  <= req_valid ? path : PATH_NONE;
        end
    end

endmodule

// File: rtl/dma_xlate_chk.sv
// Property checker for the DMA address translator, bound to every instance.
// Assumes: observes only the top-level ports.
module dma_xlate_chk #(
    parameter int SYS_AW = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [63:0]       req_addr,
    input logic              rsp_valid,
    input logic [SYS_AW-1:0] rsp_addr,
    input logic              rsp_swap,
    input logic              rsp_fault,
    input logic [1:0]        rsp_path
);

    // R2: the response strobe trails the request strobe by one cycle.
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R3: a direct 64-bit response carries the low bits of the earlier request.
    assert_direct64_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_path == 2'd1) |-> (rsp_addr == $past(req_addr[SYS_AW-1:0])));

    // R8: a fault issues no address.
    assert_fault_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_addr == '0));

    // R8: a fault never carries a swap flag.
    assert_fault_no_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_fault, rsp_swap}));

    // R10: an unmatched path always faults when a response is present.
    assert_unmapped_faults_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_path == 2'd0) |-> rsp_fault);

    // R1: a fault is only reported alongside a response.
    assert_fault_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

endmodule

bind dma_xlate dma_xlate_chk #(.SYS_AW(SYS_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_swap  (rsp_swap),
    .rsp_fault (rsp_fault),
    .rsp_path  (rsp_path)
);

// File: tb/dma_xlate_tb.sv
module dma_xlate_tb;

    localparam int AW = 40;

    typedef struct packed {
        logic [63:0] a;
        logic [2:0]  d;
        logic [1:0]  p;
        logic [39:0] eb;
        logic        fb;
        logic        sb;
        logic [39:0] ee;
        logic        fe;
        logic        se;
    } vec_t;

    // Base instance: 128 entries, per-device swap. Extended: 1024, bit-29 alias.
    // Table holds entry 3 = 0x000ABCD, entry 127 = 0x1234567, entry 5 invalid.
    localparam vec_t VECS [11] = '{
        '{64'h0100_0000_1234_5678, 3'd0, 2'd1, 40'h00_1234_5678, 1'b0, 1'b0, 40'h00_1234_5678, 1'b0, 1'b0}, // R3
        '{64'h0100_00AB_0000_0010, 3'd5, 2'd1, 40'hAB_0000_0010, 1'b0, 1'b0, 40'hAB_0000_0010, 1'b0, 1'b0}, // R3
        '{64'h0000_0000_8000_0100, 3'd0, 2'd2, 40'h01_0000_0100, 1'b0, 1'b0, 40'h01_0000_0100, 1'b0, 1'b0}, // R4
        '{64'h0000_0000_FFFF_FFFF, 3'd5, 2'd2, 40'h01_7FFF_FFFF, 1'b0, 1'b1, 40'h01_7FFF_FFFF, 1'b0, 1'b1}, // R4
        '{64'h0000_0000_4000_3ABC, 3'd0, 2'd3, 40'h00_0ABC_DABC, 1'b0, 1'b0, 40'h00_0ABC_DABC, 1'b0, 1'b0}, // R5
        '{64'h0000_0000_4007_F001, 3'd5, 2'd3, 40'h12_3456_7001, 1'b0, 1'b1, 40'h12_3456_7001, 1'b0, 1'b0}, // R7
        '{64'h0000_0000_4000_5000, 3'd0, 2'd3, 40'h0,            1'b1, 1'b0, 40'h0,            1'b1, 1'b0}, // R8
        '{64'h0000_0000_4008_0000, 3'd0, 2'd3, 40'h0,            1'b1, 1'b0, 40'h0,            1'b1, 1'b0}, // R9
        '{64'h0000_0000_3FFF_FFFF, 3'd0, 2'd0, 40'h0,            1'b1, 1'b0, 40'h0,            1'b1, 1'b0}, // R10
        '{64'h0000_0001_0000_0000, 3'd0, 2'd0, 40'h0,            1'b1, 1'b0, 40'h0,            1'b1, 1'b0}, // R10
        '{64'h0000_0000_6000_3ABC, 3'd0, 2'd3, 40'h0,            1'b1, 1'b0, 40'h00_0ABC_DABC, 1'b0, 1'b1}  // R7, R9
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              page_16k = 1'b0;
    logic [AW-1:0]     dwin_base = '0;
    logic [7:0]        dev_swap = '0;
    logic              wr_en = 1'b0;
    logic [9:0]        wr_idx = '0;
    logic              wr_valid = 1'b0;
    logic [27:0]       wr_pfn = '0;
    logic              req_valid = 1'b0;
    logic [63:0]       req_addr = '0;
    logic [2:0]        req_dev = '0;

    logic              b_valid, b_swap, b_fault, e_valid, e_swap, e_fault;
    logic [AW-1:0]     b_addr, e_addr;
    logic [1:0]        b_path, e_path;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dma_xlate #(.SYS_AW(AW), .N_DEV(8), .ENTRIES(128), .EXTENDED(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .page_16k(page_16k), .dwin_base(dwin_base),
        .dev_swap(dev_swap), .tbl_wr_en(wr_en), .tbl_wr_idx(wr_idx[6:0]),
        .tbl_wr_valid(wr_valid), .tbl_wr_pfn(wr_pfn), .req_valid(req_valid),
        .req_addr(req_addr), .req_dev(req_dev), .rsp_valid(b_valid),
        .rsp_addr(b_addr), .rsp_swap(b_swap), .rsp_fault(b_fault), .rsp_path(b_path)
    );

    dma_xlate #(.SYS_AW(AW), .N_DEV(8), .ENTRIES(1024), .EXTENDED(1'b1)) u_dut_ext (
        .clk(clk), .rst_n(rst_n), .page_16k(page_16k), .dwin_base(dwin_base),
        .dev_swap(dev_swap), .tbl_wr_en(wr_en), .tbl_wr_idx(wr_idx),
        .tbl_wr_valid(wr_valid), .tbl_wr_pfn(wr_pfn), .req_valid(req_valid),
        .req_addr(req_addr), .req_dev(req_dev), .rsp_valid(e_valid),
        .rsp_addr(e_addr), .rsp_swap(e_swap), .rsp_fault(e_fault), .rsp_path(e_path)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Present one request; outputs are sampled at the following negedge.
    task automatic request(input logic [63:0] a, input logic [2:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_dev   = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic tbl_write(input logic [9:0] i, input logic v, input logic [27:0] p);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = i; wr_valid = v; wr_pfn = p;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 base rsp_valid in reset", 64'(b_valid), 64'd0);
        chk("R1 ext rsp_valid in reset", 64'(e_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rsp_valid after reset", 64'(b_valid), 64'd0);

        // R1: all entries invalid after reset
        request(64'h4000_3ABC, 3'd0);
        chk("R1 base entry invalid", 64'(b_fault), 64'd1);
        chk("R1 ext entry invalid", 64'(e_fault), 64'd1);
        @(negedge clk);
        chk("R2 rsp_valid drops", 64'(b_valid), 64'd0);

        dwin_base = 40'h01_0000_0000;
        dev_swap  = 8'b0010_0000;
        tbl_write(10'd3, 1'b1, 28'h000ABCD);
        tbl_write(10'd127, 1'b1, 28'h1234567);
        tbl_write(10'd5, 1'b0, 28'h0FFFFFF);

        for (int i = 0; i < 11; i++) begin
            request(VECS[i].a, VECS[i].d);
            chk($sformatf("R2 vec %0d base valid", i), 64'(b_valid), 64'd1);
            chk($sformatf("R3-R10 vec %0d base addr", i), 64'(b_addr), 64'(VECS[i].eb));
            chk($sformatf("R8 vec %0d base fault", i), 64'(b_fault), 64'(VECS[i].fb));
            chk($sformatf("R7 vec %0d base swap", i), 64'(b_swap), 64'(VECS[i].sb));
            chk($sformatf("R5 vec %0d base path", i), 64'(b_path), 64'(VECS[i].p));
            chk($sformatf("R7 vec %0d ext addr", i), 64'(e_addr), 64'(VECS[i].ee));
            chk($sformatf("R9 vec %0d ext fault", i), 64'(e_fault), 64'(VECS[i].fe));
            chk($sformatf("R7 vec %0d ext swap", i), 64'(e_swap), 64'(VECS[i].se));
        end

        // R6: 16 KB pages, index 3, offset bits [13:0] kept
        page_16k = 1'b1;
        request(64'h4000_C123, 3'd0);
        chk("R6 base 16K addr", 64'(b_addr),
            64'((({12'h0, 28'h000ABCD} << 12) & ~40'h3FFF) | 40'hC123));
        chk("R6 ext 16K addr", 64'(e_addr), 64'(40'h00_0ABC_C123));
        chk("R6 base 16K fault", 64'(b_fault), 64'd0);
        page_16k = 1'b0;

        // R11: write and lookup of entry 9 in the same cycle, then next cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 10'd9; wr_valid = 1'b1; wr_pfn = 28'h0055555;
        req_valid = 1'b1; req_addr = 64'h4000_9010; req_dev = 3'd0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 base same-cycle old", 64'(b_fault), 64'd1);
        chk("R11 ext same-cycle old", 64'(e_fault), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 base next-cycle new", 64'(b_addr), 64'(40'h00_5555_5010));
        chk("R11 ext next-cycle new", 64'(e_addr), 64'(40'h00_5555_5010));

        // R12: invalidate entry 3
        tbl_write(10'd3, 1'b0, 28'h000ABCD);
        request(64'h4000_3ABC, 3'd0);
        chk("R12 base invalidated", 64'(b_fault), 64'd1);
        chk("R12 ext invalidated", 64'(e_fault), 64'd1);
        chk("R12 base addr zero", 64'(b_addr), 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule